// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bit Receiver

This block watches one open-drain debug data line that is oversampled by a fast clock. It turns every low-then-high pulse on that line into one decoded bit. A bit cell opens on a falling edge. It closes on the next falling edge, or when the line has stayed high until the cell reaches the current length limit. The bit value depends only on the shares of the cell: a low part at least as long as the high part gives 0, and a shorter low part gives 1. Cells longer than the limit plus a small tolerance are dropped.

A second path times every low on the line. A low whose length falls inside a window of plausible synchronization lengths counts as a synchronization frame. When it ends, the block pulses a sync output, which the protocol layer above uses as its reset. It also publishes the measured low length as a clock-period estimate and rescales the bit-length limit from it. The limit also adapts to the line: the first accepted bit of each sequence sets the limit to its own length. A sequence starts after reset, after a sync, and after every cell that closed by timeout.

All lengths are parameters counted in samples. The defaults suit a 32 MHz sample rate. The line input is asynchronous and passes through an internal synchronizer.

Top module: `swp_bit_rx`

## Requirements
- R1: While reset is held and after its release, with the line idle high, `bit_valid_o`, `bit_val_o`, `sync_o` and `period_o` are all 0, and the bit-length limit is `BIT_REF_INIT` samples.
- R2: A bit cell opens at a falling edge of the line. It closes at the next falling edge, or in the high sample in which low samples plus high samples reach the limit. Each accepted cell gives exactly one single-cycle `bit_valid_o` strobe.
- R3: `bit_val_o` is 0 when the count of low samples in the cell is greater than or equal to the count of high samples, and 1 otherwise. A tie gives 0.
- R4: A cell whose total length is more than the limit plus `TOL` (default 2) samples produces no strobe. A cell of exactly limit plus `TOL` samples is still accepted.
- R5: The first accepted bit after reset, after a sync, or after a cell closed by timeout sets the limit to that bit's total length in samples. Later bits leave the limit unchanged.
- R6: A low of L samples with `SYNC_MIN` <= L <= `SYNC_MAX` (defaults 232 and 1138) gives a one-cycle `sync_o` pulse in the cycle after the rising edge that ends it. Shorter or longer lows give no pulse.
- R7: `period_o` takes the length of the qualifying low in samples when `sync_o` pulses. This value is the line-clock period in samples with 7 fraction bits. `period_o` holds its value at all other times.
- R8: On a sync, the limit becomes ceil(22·L/128). The cell that the qualifying low opened is discarded, so it produces no bit.
- R9: All duration counters saturate at 2^`CNT_W`−1. A low longer than that (default 4095 samples) neither wraps into the sync window nor changes `period_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw line level, asynchronous to clk_i |
| bit_valid_o | output | 1 | One-cycle strobe for an accepted bit |
| bit_val_o | output | 1 | Bit value, valid with bit_valid_o |
| sync_o | output | 1 | One-cycle synchronization-frame pulse (protocol reset) |
| period_o | output | CNT_W | Last sync low length: line-clock period in samples, 7 fraction bits |

## Verification
The bit decoder is driven with cells that are low-heavy, high-heavy and exactly balanced, all ending on a falling edge. This separates the comparison rule and its tie case from any effect of the length limit. Cells that end by timeout use low lengths chosen so that the decoded value differs between the initial limit, the adopted limit and the rescaled limit, which shows which limit is in force. Lows just inside and just outside the tolerance, and inside and outside the sync window, mark both edges of each range. A low longer than the counter range shows whether the counters saturate or wrap.

// File: rtl/swp_pkg.sv
package swp_pkg;

   // Bit-cell phase: waiting, inside the low part, inside the high part.
   typedef enum logic [1:0] {
      CELL_IDLE = 2'd0,
      CELL_LOW  = 2'd1,
      CELL_HIGH = 2'd2
   } cell_st_t;

   // Bits needed to hold the product of a CNT_W-bit count and a constant k.
   function automatic int prod_width(input int cnt_w, input int k);
      return cnt_w + $clog2(k + 1);
   endfunction

endpackage

// File: rtl/swp_sat_cnt.sv
module swp_sat_cnt #(
   parameter int W = 12
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic         inc_i,
   output logic [W-1:0] q_o
);

   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   if (W < 2) begin : g_bad_w
      $error("swp_sat_cnt: W must be at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        q_o <= '0;
      else if (load_i)                    q_o <= W'(1);
      else if (inc_i && (q_o != CNT_MAX)) q_o <= q_o + W'(1);
   end

   // R9: a full counter that is asked to count stays at its maximum.
   p_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o == CNT_MAX && inc_i && !load_i) |=> (q_o == CNT_MAX));

   // R2: a load always restarts the count at one sample.
   p_load_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (q_o == W'(1)));

endmodule

// File: rtl/swp_line_sync.sv
module swp_line_sync #(
   parameter int   STAGES   = 2,
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   output logic level_o,
   output logic fall_o,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("swp_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   // Shift chain, reset to the idle level so no edge appears at reset release.
   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sh_q[0] <= IDLE_LVL;
            else         sh_q[0] <= line_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sh_q[i] <= IDLE_LVL;
            else         sh_q[i] <= sh_q[i-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= IDLE_LVL;
      else         prev_q <= sh_q[STAGES-1];
   end

   assign level_o = sh_q[STAGES-1];
   assign fall_o  = prev_q & ~level_o;
   assign rise_o  = ~prev_q & level_o;

endmodule

// File: rtl/swp_bit_cell.sv
module swp_bit_cell
   import swp_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int TOL   = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             level_i,
   input  logic             fall_i,
   input  logic             rise_i,
   input  logic             abort_i,
   input  logic [CNT_W-1:0] ref_i,
   output logic             bit_valid_o,
   output logic             bit_val_o,
   output logic             seq_end_o,
   output logic [CNT_W:0]   bit_len_o
);

   localparam int               SUM_W   = CNT_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [SUM_W-1:0] TOL_V   = SUM_W'(TOL);

   cell_st_t         st_q, st_d;
   logic [CNT_W-1:0] low_q, high_q, high_nxt;
   logic             low_ld, low_inc, high_ld, high_inc;
   logic             in_high, end_fall, end_exp, cell_one, accept;
   logic [SUM_W-1:0] sum_run, sum_fall, cell_len, ref_w, lim;

   swp_sat_cnt #(.W(CNT_W)) u_low_cnt (
      .clk_i (clk_i), .rst_ni(rst_ni),
      .load_i(low_ld), .inc_i(low_inc), .q_o(low_q)
   );

   swp_sat_cnt #(.W(CNT_W)) u_high_cnt (
      .clk_i (clk_i), .rst_ni(rst_ni),
      .load_i(high_ld), .inc_i(high_inc), .q_o(high_q)
   );

   assign low_ld   = fall_i;
   assign low_inc  = (st_q == CELL_LOW) && !level_i;
   assign high_ld  = (st_q == CELL_LOW) && rise_i;
   assign high_inc = (st_q == CELL_HIGH) && level_i;

   // High-sample count including the current sample.
   assign high_nxt = (st_q == CELL_LOW) ? CNT_W'(1)
                   : ((high_q == CNT_MAX) ? high_q : high_q + CNT_W'(1));

   assign in_high  = ((st_q == CELL_LOW) && rise_i)
                  || ((st_q == CELL_HIGH) && level_i && !fall_i);
   assign sum_run  = {1'b0, low_q} + {1'b0, high_nxt};
   assign sum_fall = {1'b0, low_q} + {1'b0, high_q};
   assign ref_w    = {1'b0, ref_i};
   assign lim      = ref_w + TOL_V;

   assign end_fall = (st_q == CELL_HIGH) && fall_i;
   assign end_exp  = in_high && !abort_i && (sum_run >= ref_w);
   assign cell_len = end_fall ? sum_fall : sum_run;
   assign cell_one = end_fall ? (low_q < high_q) : (low_q < high_nxt);
   assign accept   = (end_fall || end_exp) && (cell_len <= lim);

   always_comb begin
      st_d = st_q;
      if (fall_i)                           st_d = CELL_LOW;
      else if (abort_i)                     st_d = CELL_IDLE;
      else if (end_exp)                     st_d = CELL_IDLE;
      else if ((st_q == CELL_LOW) && rise_i) st_d = CELL_HIGH;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q        <= CELL_IDLE;
         bit_valid_o <= 1'b0;
         bit_val_o   <= 1'b0;
         seq_end_o   <= 1'b0;
         bit_len_o   <= '0;
      end else begin
         st_q        <= st_d;
         bit_valid_o <= accept;
         seq_end_o   <= end_exp;
         if (accept) begin
            bit_val_o <= cell_one;
            bit_len_o <= cell_len;
         end
      end
   end

   // R4: every strobed cell fits inside the limit plus tolerance.
   p_len_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_valid_o |-> (bit_len_o <= ({1'b0, ref_i} + TOL_V)));

   // R2: strobes are single cycles.
   p_strobe_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_valid_o |=> !bit_valid_o);

   // R8: a cell abandoned for a sync frame yields no bit.
   p_abort_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_i |=> !bit_valid_o);

endmodule

// File: rtl/swp_sync_det.sv
module swp_sync_det
   import swp_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter int SYNC_MIN   = 232,
   parameter int SYNC_MAX   = 1138,
   parameter int BIT_CLKS   = 22,
   parameter int SCALE_LOG2 = 7,
   parameter bit ROUND_CEIL = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             level_i,
   input  logic             fall_i,
   input  logic             rise_i,
   output logic             hit_o,
   output logic             sync_o,
   output logic [CNT_W-1:0] period_o,
   output logic [CNT_W-1:0] ref_new_o
);

   localparam int               PROD_W = prod_width(CNT_W, BIT_CLKS);
   localparam logic [CNT_W-1:0] WIN_LO = CNT_W'(SYNC_MIN);
   localparam logic [CNT_W-1:0] WIN_HI = CNT_W'(SYNC_MAX);

   logic [CNT_W-1:0]  low_len;
   logic [PROD_W-1:0] prod, scaled;

   swp_sat_cnt #(.W(CNT_W)) u_len_cnt (
      .clk_i (clk_i), .rst_ni(rst_ni),
      .load_i(fall_i), .inc_i(!level_i), .q_o(low_len)
   );

   assign hit_o = rise_i && (low_len >= WIN_LO) && (low_len <= WIN_HI);
   assign prod  = PROD_W'(low_len) * PROD_W'(BIT_CLKS);

   if (ROUND_CEIL) begin : g_ceil
      assign scaled = (prod + PROD_W'((1 << SCALE_LOG2) - 1)) >> SCALE_LOG2;
   end else begin : g_floor
      assign scaled = prod >> SCALE_LOG2;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_o    <= 1'b0;
         period_o  <= '0;
         ref_new_o <= '0;
      end else begin
         sync_o <= hit_o;
         if (hit_o) begin
            period_o  <= low_len;
            ref_new_o <= CNT_W'(scaled);
         end
      end
   end

   // R6: a published period always lies in the sync window.
   p_sync_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_o |-> ((period_o >= WIN_LO) && (period_o <= WIN_HI)));

   // R7: the period estimate moves only together with a sync pulse.
   p_per_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sync_o |-> $stable(period_o));

endmodule

// File: rtl/swp_bit_rx.sv
module swp_bit_rx #(
   parameter int CNT_W        = 12,
   parameter int SYNC_STAGES  = 2,
   parameter int BIT_REF_INIT = 196,
   parameter int TOL          = 2,
   parameter int SYNC_MIN     = 232,
   parameter int SYNC_MAX     = 1138,
   parameter int BIT_CLKS     = 22,
   parameter int SCALE_LOG2   = 7,
   parameter bit ROUND_CEIL   = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             line_i,
   output logic             bit_valid_o,
   output logic             bit_val_o,
   output logic             sync_o,
   output logic [CNT_W-1:0] period_o
);

   localparam int               CNT_TOP = (1 << CNT_W) - 1;
   localparam logic [CNT_W-1:0] REF_RST = CNT_W'(BIT_REF_INIT);
   localparam logic [CNT_W-1:0] REF_SAT = {CNT_W{1'b1}};

   if (SYNC_MIN < 1 || SYNC_MIN > SYNC_MAX || SYNC_MAX >= CNT_TOP) begin : g_bad_win
      $error("swp_bit_rx: sync window must satisfy 1 <= MIN <= MAX < counter top");
   end
   if (BIT_REF_INIT < 2 || BIT_REF_INIT + TOL >= CNT_TOP) begin : g_bad_ref
      $error("swp_bit_rx: BIT_REF_INIT out of range for CNT_W");
   end
   if (TOL < 0 || BIT_CLKS < 1 || SCALE_LOG2 < 1) begin : g_bad_scale
      $error("swp_bit_rx: TOL, BIT_CLKS or SCALE_LOG2 invalid");
   end

   logic             level, fall, rise, hit, seq_end, seq_first_q;
   logic [CNT_W:0]   bit_len;
   logic [CNT_W-1:0] ref_q, ref_new;

   swp_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_i),
      .level_o(level),
      .fall_o (fall),
      .rise_o (rise)
   );

   swp_bit_cell #(.CNT_W(CNT_W), .TOL(TOL)) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .level_i    (level),
      .fall_i     (fall),
      .rise_i     (rise),
      .abort_i    (hit),
      .ref_i      (ref_q),
      .bit_valid_o(bit_valid_o),
      .bit_val_o  (bit_val_o),
      .seq_end_o  (seq_end),
      .bit_len_o  (bit_len)
   );

   swp_sync_det #(
      .CNT_W     (CNT_W),
      .SYNC_MIN  (SYNC_MIN),
      .SYNC_MAX  (SYNC_MAX),
      .BIT_CLKS  (BIT_CLKS),
      .SCALE_LOG2(SCALE_LOG2),
      .ROUND_CEIL(ROUND_CEIL)
   ) u_sync (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .level_i  (level),
      .fall_i   (fall),
      .rise_i   (rise),
      .hit_o    (hit),
      .sync_o   (sync_o),
      .period_o (period_o),
      .ref_new_o(ref_new)
   );

   // Limit register: rescaled on sync, adopted from the first bit of a sequence.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ref_q       <= REF_RST;
         seq_first_q <= 1'b1;
      end else begin
         if (sync_o)
            ref_q <= ref_new;
         else if (bit_valid_o && seq_first_q)
            ref_q <= bit_len[CNT_W] ? REF_SAT : bit_len[CNT_W-1:0];

         if (sync_o || seq_end)  seq_first_q <= 1'b1;
         else if (bit_valid_o)   seq_first_q <= 1'b0;
      end
   end

   // R5: the limit never collapses to zero.
   p_ref_positive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_q != '0);

   // R8: a sync pulse and a bit strobe never coincide.
   p_sync_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_o |-> !bit_valid_o);

endmodule

// File: tb/swp_bit_rx_tb.sv
`timescale 1ns/1ps
module swp_bit_rx_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_i = 1'b1;
   logic        bit_valid_o, bit_val_o, sync_o;
   logic [11:0] period_o;

   int    checks = 0;
   int    fails  = 0;
   int    exp_bits[$];
   string bit_tags[$];
   int    exp_per[$];
   string per_tags[$];
   int    got;
   string tg;

   always #2.5 clk = ~clk;

   swp_bit_rx dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .line_i     (line_i),
      .bit_valid_o(bit_valid_o),
      .bit_val_o  (bit_val_o),
      .sync_o     (sync_o),
      .period_o   (period_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int n);
      line_i = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic push_bit(input int v, input string tag);
      exp_bits.push_back(v);
      bit_tags.push_back(tag);
   endtask

   task automatic push_per(input int v, input string tag);
      exp_per.push_back(v);
      per_tags.push_back(tag);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // Monitor: compares strobes and sync pulses against the scoreboard queues.
   always @(negedge clk) begin
      if (rst_n) begin
         if (bit_valid_o) begin
            if (exp_bits.size() == 0) begin
               chk(1'b0, "R2 unexpected bit strobe", int'(bit_val_o), -1);
            end else begin
               got = exp_bits.pop_front();
               tg  = bit_tags.pop_front();
               chk(int'(bit_val_o) == got, tg, int'(bit_val_o), got);
            end
         end
         if (sync_o) begin
            if (exp_per.size() == 0) begin
               chk(1'b0, "R6 unexpected sync pulse", int'(period_o), -1);
            end else begin
               got = exp_per.pop_front();
               tg  = per_tags.pop_front();
               chk(int'(period_o) == got, tg, int'(period_o), got);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (5) @(negedge clk);
      chk(bit_valid_o == 1'b0, "R1 strobe in reset", int'(bit_valid_o), 0);
      chk(sync_o == 1'b0, "R1 sync in reset", int'(sync_o), 0);
      chk(period_o == 12'd0, "R1 period in reset", int'(period_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(bit_valid_o == 1'b0 && bit_val_o == 1'b0, "R1 strobe after reset", int'(bit_valid_o), 0);
      chk(sync_o == 1'b0, "R1 sync after reset", int'(sync_o), 0);
      hold(1'b1, 20);

      // Sequence 1: first bit sets the limit to 42, then balanced-length cells.
      push_bit(0, "R2 first cell low 32 high 10");
      hold(1'b0, 32); hold(1'b1, 10);
      push_bit(1, "R3 low 10 high 30");
      hold(1'b0, 10); hold(1'b1, 30);
      push_bit(0, "R3 tie low 20 high 20");
      hold(1'b0, 20); hold(1'b1, 20);
      push_bit(0, "R3 low 25 high 15");
      hold(1'b0, 25); hold(1'b1, 15);
      // Ends by timeout at 42 samples: high 20 gives 0 (1 under the initial 196 limit).
      push_bit(0, "R5 timeout under adopted limit");
      hold(1'b0, 22); hold(1'b1, 300);
      chk(exp_bits.size() == 0, "R2 all cells of sequence 1 seen", exp_bits.size(), 0);

      // Sequence 2: limit 42, low 43 ends at 44 = limit + TOL, accepted.
      push_bit(0, "R5 first cell of sequence 2");
      hold(1'b0, 22); hold(1'b1, 20);
      push_bit(0, "R4 cell at limit plus tolerance");
      hold(1'b0, 43); hold(1'b1, 300);

      // Sequence 3: low 45 gives 46 > 44, dropped.
      push_bit(0, "R5 first cell of sequence 3");
      hold(1'b0, 22); hold(1'b1, 20);
      hold(1'b0, 45); hold(1'b1, 300);
      chk(exp_bits.size() == 0, "R4 over-long cell dropped", exp_bits.size(), 0);

      // Sync of 512 samples: limit becomes 88, cell discarded.
      push_per(512, "R7 period after 512-sample sync");
      hold(1'b0, 512); hold(1'b1, 300);
      chk(exp_per.size() == 0, "R6 sync pulse seen", exp_per.size(), 0);
      chk(exp_bits.size() == 0, "R8 no bit from sync low", exp_bits.size(), 0);
      // Low 50 times out at 88: high 38 gives 0 (dropped under 42, 1 under 196).
      push_bit(0, "R8 rescaled limit 88");
      hold(1'b0, 50); hold(1'b1, 300);

      // Lows outside the window.
      hold(1'b0, 200);  hold(1'b1, 300);
      hold(1'b0, 1200); hold(1'b1, 300);
      chk(exp_per.size() == 0 && exp_bits.size() == 0, "R6 no sync outside window",
          exp_per.size() + exp_bits.size(), 0);
      chk(period_o == 12'd512, "R7 period held", int'(period_o), 512);

      // Window edges.
      push_per(232, "R6 sync at lower bound");
      hold(1'b0, 232);  hold(1'b1, 300);
      push_per(1138, "R6 sync at upper bound");
      hold(1'b0, 1138); hold(1'b1, 300);
      chk(exp_per.size() == 0, "R6 both edge syncs seen", exp_per.size(), 0);

      // Low beyond counter range: saturates, no wrap into the window.
      hold(1'b0, 4395); hold(1'b1, 300);
      chk(period_o == 12'd1138, "R9 period unchanged after overflow low", int'(period_o), 1138);
      chk(exp_per.size() == 0 && exp_bits.size() == 0, "R9 no pulse after overflow low",
          exp_per.size() + exp_bits.size(), 0);

      summary();
      $finish;
   end

endmodule